// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shift Register

This block walks a single active bit across the gate-line outputs of a display row driver. A start pulse is taken in on the rising edge of the shift clock. After that, one output at a time goes high, and the active output moves by one position on every further rising edge. The scan runs either from the lowest output upward or from the highest output downward. The active span can be 128 outputs or a shortened span of 120. When the scan reaches the end of the active span, a one-period cascade pulse is produced on falling clock edges so that the next driver in a chain can start its own scan.

Each of the two start pins is bidirectional and is modelled as an input, an output and a drive-enable. The direction input decides which pin receives the start pulse and which pin sends out the cascade pulse. A blanking input forces every scan output low, combinationally and with no synchronisation to the clock. While blanking is active, the register keeps its contents and keeps shifting.

Top module: `scan_shift_driver`

## Requirements
- R1: While rst_ni is low, every bit of scan_o is 0 and both start_r_o and start_l_o are 0.
- R2: A start pulse that is high at a rising clock edge is captured by that edge, which counts as pulse 1. Right after it, the first output in scan order is high.
- R3: With dir_right_i = 1, the start pulse is taken from start_r_i and start_l_i is ignored. After pulse p, only scan_o bit p-1 is high (bit i is output i+1).
- R4: With dir_right_i = 0, the start pulse is taken from start_l_i. After pulse p, only scan_o bit 128-p is high.
- R5: With mode120_i = 1, scan positions 121 to 128 stay low. These are scan_o bits 127:120 when shifting right and bits 7:0 when shifting left.
- R6: With mode120_i = 0, the cascade pin goes high on the falling edge of pulse 128 and low on the falling edge of pulse 129.
- R7: With mode120_i = 1, the cascade pin goes high on the falling edge of pulse 120 and low on the falling edge of pulse 121.
- R8: With dir_right_i = 1, start_l is the cascade output: start_l_oe_o = 1, start_r_oe_o = 0, and start_r_o = 0. With dir_right_i = 0, the roles swap.
- R9: While oe_blank_i = 1, scan_o is all 0, including within the same clock period it is raised. The register keeps shifting, so after release the output is at the position it would have reached without blanking. Blanking does not affect the cascade pulse.
- R10: A single captured start pulse gives at most one high scan output in any clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode120_i | input | 1 | 1 = 120 active outputs, 0 = 128 |
| dir_right_i | input | 1 | 1 = scan from output 1 upward, 0 = downward |
| oe_blank_i | input | 1 | 1 = force all scan outputs low (asynchronous) |
| start_r_i | input | 1 | Right start pin, input side |
| start_r_o | output | 1 | Right start pin, cascade drive value |
| start_r_oe_o | output | 1 | Right start pin drive enable |
| start_l_i | input | 1 | Left start pin, input side |
| start_l_o | output | 1 | Left start pin, cascade drive value |
| start_l_oe_o | output | 1 | Left start pin drive enable |
| scan_o | output | 128 | Gate-line scan outputs, bit i = output i+1 |

## Verification
Blanking and the cascade pulse can coincide. The bench raises oe_blank_i mid-period and holds it across the end-of-span pulses. It checks that scan_o is zero within the same period, that the cascade pin still rises and falls on the falling edges of the expected pulses, and that after release the active output is at the position the unblanked scan would have reached. Separately, a table of mode, direction and pulse-count vectors checks the position and mask of the active bit in both directions and at both span ends.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    SCAN_LEFT  = 1'b0,
    SCAN_RIGHT = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int N_OUT = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [N_OUT-1:0] chain_o
);
  logic [N_OUT-1:0] chain_q;

  // index is scan order: 0 is the first position after capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[N_OUT-2:0], start_i};
  end

  assign chain_o = chain_q;

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> chain_q[0]);

  // R10
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_q[0] |=> chain_q[1]);
endmodule

// File: rtl/scan_out_map.sv
module scan_out_map #(
  parameter int N_OUT   = 128,
  parameter int N_SHORT = 120
) (
  input  logic [N_OUT-1:0] chain_i,
  input  logic             dir_right_i,
  input  logic             short_i,
  input  logic             blank_i,
  output logic [N_OUT-1:0] scan_o
);
  logic [N_OUT-1:0] live;

  // mask positions past the short span in scan order
  for (genvar k = 0; k < N_OUT; k++) begin : g_live
    if (k < N_SHORT) begin : g_keep
      assign live[k] = chain_i[k];
    end else begin : g_spare
      assign live[k] = chain_i[k] & ~short_i;
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_phys
    assign scan_o[i] = ~blank_i & (dir_right_i ? live[i] : live[N_OUT-1-i]);
  end
endmodule

// File: rtl/scan_cascade.sv
module scan_cascade (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_right_i,
  input  logic short_i,
  input  logic tap_long_i,
  input  logic tap_short_i,
  input  logic start_r_i,
  input  logic start_l_i,
  output logic shift_in_o,
  output logic start_r_o,
  output logic start_r_oe_o,
  output logic start_l_o,
  output logic start_l_oe_o
);
  logic casc_q;
  logic tap;

  assign tap = short_i ? tap_short_i : tap_long_i;

  // falling-edge stage: rises at the end of the last pulse, drops one period later
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_q <= 1'b0;
    else         casc_q <= tap;
  end

  assign shift_in_o   = dir_right_i ? start_r_i : start_l_i;
  assign start_l_oe_o = dir_right_i;
  assign start_r_oe_o = ~dir_right_i;
  assign start_l_o    = dir_right_i & casc_q;
  assign start_r_o    = ~dir_right_i & casc_q;

  // R6
  casc_long_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!short_i && tap_long_i) |=> casc_q);

  // R7
  casc_short_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (short_i && tap_short_i) |=> casc_q);

  // R8
  steer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_r_oe_o && start_r_o) && !(start_l_oe_o && start_l_o) ? 1'b1 :
    $onehot({start_r_oe_o, start_l_oe_o}));
endmodule

// File: rtl/scan_shift_driver.sv
module scan_shift_driver
  import scan_pkg::*;
#(
  parameter int N_OUT   = 128,
  parameter int N_SHORT = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode120_i,
  input  logic             dir_right_i,
  input  logic             oe_blank_i,
  input  logic             start_r_i,
  output logic             start_r_o,
  output logic             start_r_oe_o,
  input  logic             start_l_i,
  output logic             start_l_o,
  output logic             start_l_oe_o,
  output logic [N_OUT-1:0] scan_o
);
  localparam int N_SPARE = N_OUT - N_SHORT;

  logic [N_OUT-1:0] chain;
  logic             shift_in;
  logic             dir_right;

  assign dir_right = (scan_dir_e'(dir_right_i) == SCAN_RIGHT);

  scan_cascade u_casc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_right_i  (dir_right),
    .short_i      (mode120_i),
    .tap_long_i   (chain[N_OUT-1]),
    .tap_short_i  (chain[N_SHORT-1]),
    .start_r_i    (start_r_i),
    .start_l_i    (start_l_i),
    .shift_in_o   (shift_in),
    .start_r_o    (start_r_o),
    .start_r_oe_o (start_r_oe_o),
    .start_l_o    (start_l_o),
    .start_l_oe_o (start_l_oe_o)
  );

  scan_chain #(.N_OUT(N_OUT)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (shift_in),
    .chain_o (chain)
  );

  scan_out_map #(.N_OUT(N_OUT), .N_SHORT(N_SHORT)) u_map (
    .chain_i     (chain),
    .dir_right_i (dir_right),
    .short_i     (mode120_i),
    .blank_i     (oe_blank_i),
    .scan_o      (scan_o)
  );

  // R5
  mask_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode120_i && dir_right_i) |-> (scan_o[N_OUT-1:N_SHORT] == '0));

  // R5
  mask_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode120_i && !dir_right_i) |-> (scan_o[N_SPARE-1:0] == '0));

  // R9
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_blank_i |-> (scan_o == '0));
endmodule

// File: tb/scan_shift_driver_test.sv
module scan_shift_driver_test;
  localparam int CLK_P = 10;
  localparam int NV    = 11;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode120 = 1'b0, dir_right = 1'b1, blank = 1'b0;
  logic         sr_i = 1'b0, sl_i = 1'b0;
  logic         sr_o, sr_oe, sl_o, sl_oe;
  logic [127:0] scan;
  int           n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  scan_shift_driver uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode120_i(mode120), .dir_right_i(dir_right),
    .oe_blank_i(blank), .start_r_i(sr_i), .start_r_o(sr_o), .start_r_oe_o(sr_oe),
    .start_l_i(sl_i), .start_l_o(sl_o), .start_l_oe_o(sl_oe), .scan_o(scan)
  );

  // {mode120, dir_right, pulse count, expected bit (255 = none)}
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd1,   8'd0},
    {1'b0, 1'b1, 8'd5,   8'd4},
    {1'b0, 1'b1, 8'd128, 8'd127},
    {1'b0, 1'b0, 8'd1,   8'd127},
    {1'b0, 1'b0, 8'd3,   8'd125},
    {1'b0, 1'b0, 8'd128, 8'd0},
    {1'b1, 1'b1, 8'd120, 8'd119},
    {1'b1, 1'b1, 8'd121, 8'd255},
    {1'b1, 1'b0, 8'd120, 8'd8},
    {1'b1, 1'b0, 8'd121, 8'd255},
    {1'b1, 1'b0, 8'd124, 8'd255}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // reset, then capture a start pulse as pulse 1; returns at pulse 1 edge + 1
  task automatic launch(input logic m, input logic d);
    rst_ni = 1'b0; blank = 1'b0; sr_i = 1'b0; sl_i = 1'b0;
    mode120 = m; dir_right = d;
    repeat (2) step();
    rst_ni = 1'b1;
    if (d) sr_i = 1'b1; else sl_i = 1'b1;
    step();
    sr_i = 1'b0; sl_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) step();
    check(scan == '0, "R1 scan", scan, '0);
    check({sr_o, sl_o} == 2'b00, "R1 cascade", {sr_o, sl_o}, 0);

    // table walk: R2 R3 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      logic [127:0] exp;
      int p;
      p = int'(VEC[v][15:8]);
      exp = (VEC[v][7:0] == 8'd255) ? '0 : (128'b1 << VEC[v][7:0]);
      launch(VEC[v][17], VEC[v][16]);
      repeat (p - 1) step();
      #2;
      check(scan == exp, VEC[v][17] ? "R5 mask/position" :
            (VEC[v][16] ? "R3 right position" : "R4 left position"), scan, exp);
      check($countones(scan) <= 1, "R10 single active", $countones(scan), 1);
      if (p == 1) check(scan == exp, "R2 capture", scan, exp);
    end

    // R8 steering
    rst_ni = 1'b1; dir_right = 1'b1; #1;
    check({sr_oe, sl_oe, sr_o} == 3'b010, "R8 right steer", {sr_oe, sl_oe, sr_o}, 3'b010);
    dir_right = 1'b0; #1;
    check({sr_oe, sl_oe, sl_o} == 3'b100, "R8 left steer", {sr_oe, sl_oe, sl_o}, 3'b100);

    // R3 wrong-side start pin ignored
    launch(1'b0, 1'b1);
    sl_i = 1'b1; step(); step(); sl_i = 1'b0;
    check(scan == (128'b1 << 2), "R3 start_l ignored", scan, 128'b1 << 2);

    // R6 cascade 128 mode, right
    launch(1'b0, 1'b1);
    repeat (126) step();
    #7; check(sl_o == 1'b0, "R6 low after pulse 127", sl_o, 0);
    @(posedge clk); #3; check(sl_o == 1'b0, "R6 low before fall 128", sl_o, 0);
    #5; check(sl_o == 1'b1, "R6 high after fall 128", sl_o, 1);
    check(sr_o == 1'b0, "R8 input pin quiet", sr_o, 0);
    @(posedge clk); #3; check(sl_o == 1'b1, "R6 held in pulse 129", sl_o, 1);
    #5; check(sl_o == 1'b0, "R6 low after fall 129", sl_o, 0);

    // R6 cascade 128 mode, left
    launch(1'b0, 1'b0);
    repeat (127) step();
    #7; check(sr_o == 1'b1, "R6 left cascade high", sr_o, 1);

    // R7 cascade 120 mode
    launch(1'b1, 1'b1);
    repeat (118) step();
    #7; check(sl_o == 1'b0, "R7 low after fall 119", sl_o, 0);
    @(posedge clk); #8; check(sl_o == 1'b1, "R7 high after fall 120", sl_o, 1);
    @(posedge clk); #8; check(sl_o == 1'b0, "R7 low after fall 121", sl_o, 0);

    // R9 blank mid-period, keep shifting, cascade unaffected
    launch(1'b0, 1'b1);
    repeat (9) step();
    #1; blank = 1'b1; #1;
    check(scan == '0, "R9 blank same period", scan, '0);
    repeat (5) step();
    check(scan == '0, "R9 blank held", scan, '0);
    blank = 1'b0; #1;
    check(scan == (128'b1 << 14), "R9 position after release", scan, 128'b1 << 14);
    blank = 1'b1;
    repeat (113) step();
    #6; check(sl_o == 1'b1, "R9 cascade during blank", sl_o, 1);
    check(scan == '0, "R9 blank at span end", scan, '0);
    @(posedge clk); #8; check(sl_o == 1'b0, "R9 cascade drops during blank", sl_o, 0);
    blank = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule